// File: doc/BRIEF.md
# HDLC Octet-Mode Receive Packet Processor

This block sits behind the receive line and takes an octet-aligned HDLC byte stream, one byte per cycle when `in_valid` is high. It waits for the first flag, then removes the escape sequences from each frame. It runs a 16-bit or 32-bit frame check over every recovered byte. When the closing flag arrives it reports whether the frame is good. Recovered bytes leave as a beat stream with start, end and error markers. A downstream FIFO uses the end marker to commit the packet or to rewind it.

The length of a frame counts every recovered byte between its flags, the check bytes included. On its end beat the frame gets one of four results: aborted, size violation, check failure or good. Each failed result has its own saturating counter. Configuration comes from static ports and may change only while no frame is open.

Top module: `hdlc_rx_pkt`

## Requirements
- R1: After reset, bytes that arrive before the first 0x7E are ignored and produce no output beat.
- R2: Every 0x7E closes the open frame and opens a new one. A frame with no recovered bytes, for example between back-to-back flags, produces no beat and changes no counter.
- R3: A 0x7D byte is dropped, and the byte after it is recovered as that byte XOR 0x20. A 0x7D followed by 0x7D recovers 0x5D.
- R4: With `cfg_fcs32`=0 the check is the reflected CCITT 16-bit CRC (init 0xFFFF, good residue 0xF0B8). With `cfg_fcs32`=1 it is the reflected 32-bit CRC (init 0xFFFFFFFF, good residue 0xDEBB20E3). The check bytes are sent least significant byte first. A frame that fails the check raises `cnt_fcs` and is marked errored.
- R5: With `cfg_keep_fcs`=1 every recovered byte is output. With `cfg_keep_fcs`=0 the last 2 or 4 recovered bytes of the frame (2 for the 16-bit check, 4 for the 32-bit check) are not output.
- R6: A frame of length L is a size violation if L is not larger than the check length, if L < `cfg_min_len`, or if L > `cfg_max_len`. Such a frame raises `cnt_size` and is marked errored.
- R7: A 0x7D directly followed by 0x7E aborts the open frame and raises `cnt_abort`. Each closed frame raises at most one counter, in the priority abort, then size, then check.
- R8: The end beat of an errored frame carries `out_err` when `cfg_fwd_err`=1 and `out_drop` when `cfg_fwd_err`=0. A good frame carries neither.
- R9: Output is registered. With a hold depth D (1 when keeping the check bytes, otherwise 1 plus the check length), a frame of length L yields the recovered bytes 0..max(L-D,0) in order. `out_sop` is set on the first beat and `out_eop` on the last.
- R10: Each counter saturates at its all-ones value. `cnt_clr` clears all three on the next edge and takes priority over an increment.
- R11: Synchronous active-low reset clears all outputs and counters to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Received line byte |
| cfg_fcs32 | input | 1 | 1 selects the 32-bit check, 0 the 16-bit check |
| cfg_keep_fcs | input | 1 | 1 forwards the check bytes, 0 strips them |
| cfg_fwd_err | input | 1 | 1 marks errored frames with out_err, 0 with out_drop |
| cfg_min_len | input | LEN_W | Minimum frame length in bytes |
| cfg_max_len | input | LEN_W | Maximum frame length in bytes |
| cnt_clr | input | 1 | Clear pulse for the three counters |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 8 | Recovered byte |
| out_sop | output | 1 | First beat of a frame |
| out_eop | output | 1 | Last beat of a frame |
| out_err | output | 1 | Errored frame, forwarded (end beat only) |
| out_drop | output | 1 | Errored frame, discard requested (end beat only) |
| cnt_abort | output | CNT_W | Aborted frame count |
| cnt_size | output | CNT_W | Size violation count |
| cnt_fcs | output | CNT_W | Check failure count |

## Verification
The assertions assume that the configuration ports hold still while a frame is open. Once a closing flag has emptied the hold line, a new setting is safe. The stimulus therefore changes the configuration only after a closing flag and several idle cycles. The assertions also assume that `cnt_clr` is a pulse, and the bench pulses it only at the end, after the counters have been compared. Random frames mix in flag and escape values, random idle gaps, corrupted check bytes and aborts. Directed frames sit on each side of the minimum and maximum length limits.

// File: rtl/hdlc_rx_pkg.sv
// Shared constants, event type and CRC byte-update functions for the
// HDLC receive packet processor. Assumes reflected (LSB-first) CRCs.
package hdlc_rx_pkg;
    localparam logic [7:0]  FLAG_BYTE = 8'h7E;
    localparam logic [7:0]  ESC_BYTE  = 8'h7D;
    localparam logic [7:0]  ESC_XOR   = 8'h20;
    localparam logic [15:0] C16_INIT  = 16'hFFFF;
    localparam logic [15:0] C16_GOOD  = 16'hF0B8;
    localparam logic [15:0] C16_POLY  = 16'h8408;
    localparam logic [31:0] C32_INIT  = 32'hFFFF_FFFF;
    localparam logic [31:0] C32_GOOD  = 32'hDEBB_20E3;
    localparam logic [31:0] C32_POLY  = 32'hEDB8_8320;

    typedef enum logic [1:0] {EV_NONE, EV_DATA, EV_CLOSE, EV_ABORT} rx_ev_e;

    // One byte through the 16-bit reflected CRC.
    function automatic logic [15:0] crc16_byte(logic [15:0] c, logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ C16_POLY) : (r >> 1);
        return r;
    endfunction

    // One byte through the 32-bit reflected CRC.
    function automatic logic [31:0] crc32_byte(logic [31:0] c, logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ C32_POLY) : (r >> 1);
        return r;
    endfunction
endpackage

// File: rtl/hdlc_rx_destuff.sv
// Flag hunt and octet destuffing. Turns each valid line byte into one
// event: recovered data, frame close, frame abort or nothing.
// Assumes one byte per cycle at most, qualified by in_valid.
module hdlc_rx_destuff
    import hdlc_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output rx_ev_e     ev,
    output logic [7:0] ev_byte
);
    logic synced_q;
    logic esc_q;

    // Classify the current byte from the escape and hunt state.
    always_comb begin
        ev      = EV_NONE;
        ev_byte = esc_q ? (in_byte ^ ESC_XOR) : in_byte;
        if (in_valid && synced_q) begin
            if (in_byte == FLAG_BYTE)                 ev = esc_q ? EV_ABORT : EV_CLOSE;
            else if (in_byte != ESC_BYTE || esc_q)    ev = EV_DATA;
        end
    end

    // Track the first flag seen and a pending escape.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            synced_q <= 1'b0;
            esc_q    <= 1'b0;
        end else if (in_valid) begin
            if (in_byte == FLAG_BYTE) begin
                synced_q <= 1'b1;
                esc_q    <= 1'b0;
            end else begin
                esc_q <= synced_q && !esc_q && (in_byte == ESC_BYTE);
            end
        end
    end

    assert_flag_clears_escape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_byte == FLAG_BYTE) |=> !esc_q);
    assert_no_event_in_hunt_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !synced_q |-> ev == EV_NONE);
endmodule

// File: rtl/hdlc_rx_fcs.sv
// Running frame check. Both CRC widths advance on every recovered byte;
// cfg_fcs32 picks which residue decides the verdict. Assumes restart
// is pulsed on every frame close.
module hdlc_rx_fcs
    import hdlc_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       upd,
    input  logic [7:0] data,
    input  logic       fcs32,
    output logic       good
);
    logic [15:0] c16_q;
    logic [31:0] c32_q;

    // Advance or reload both CRC registers.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            c16_q <= C16_INIT;
            c32_q <= C32_INIT;
        end else if (upd) begin
            c16_q <= crc16_byte(c16_q, data);
            c32_q <= crc32_byte(c32_q, data);
        end
    end

    // Compare against the selected good residue.
    always_comb good = fcs32 ? (c32_q == C32_GOOD) : (c16_q == C16_GOOD);

    assert_restart_reloads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (c16_q == C16_INIT && c32_q == C32_INIT));
endmodule

// File: rtl/hdlc_rx_sat_ctr.sv
// Saturating event counter with a synchronous clear that wins over an
// increment. Assumes inc is a single-cycle pulse per event.
module hdlc_rx_sat_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    // Count up to the top value, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)              count <= '0;
        else if (inc && count != TOP)   count <= count + 1'b1;
    end

    assert_hold_at_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && count == TOP) |=> count == TOP);
    assert_clear_to_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
endmodule

// File: rtl/hdlc_rx_pkt.sv
// HDLC receive packet processor, octet mode. Destuffs, checks length and
// CRC, optionally strips the check bytes and marks errored frames on the
// end beat. Assumes configuration is static while a frame is open.
module hdlc_rx_pkt
    import hdlc_rx_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             cfg_fcs32,
    input  logic             cfg_keep_fcs,
    input  logic             cfg_fwd_err,
    input  logic [LEN_W-1:0] cfg_min_len,
    input  logic [LEN_W-1:0] cfg_max_len,
    input  logic             cnt_clr,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sop,
    output logic             out_eop,
    output logic             out_err,
    output logic             out_drop,
    output logic [CNT_W-1:0] cnt_abort,
    output logic [CNT_W-1:0] cnt_size,
    output logic [CNT_W-1:0] cnt_fcs
);
    localparam int FCS_MAX = 4;
    localparam int HOLD    = 1 + FCS_MAX;
    localparam int HW      = $clog2(HOLD + 1);
    localparam int NCTR    = 3;

    rx_ev_e           ev;
    logic [7:0]       ev_byte;
    logic             fcs_good;
    logic [LEN_W:0]   len_q;
    logic [HW-1:0]    held_q;
    logic [7:0]       line_q [HOLD];
    logic             started_q;
    logic [HW-1:0]    fcs_len;
    logic [HW-1:0]    depth;
    logic             closing;
    logic             close_any;
    logic             size_bad;
    logic             frame_bad;
    logic [NCTR-1:0]  inc_vec;
    logic [CNT_W-1:0] cnt_arr [NCTR];

    hdlc_rx_destuff u_destuff (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .ev(ev), .ev_byte(ev_byte)
    );

    hdlc_rx_fcs u_fcs (
        .clk(clk), .rst_n(rst_n), .restart(closing), .upd(ev == EV_DATA),
        .data(ev_byte), .fcs32(cfg_fcs32), .good(fcs_good)
    );

    // Derive the check length, hold depth and close-time verdict.
    always_comb begin
        fcs_len   = cfg_fcs32 ? HW'(4) : HW'(2);
        depth     = cfg_keep_fcs ? HW'(1) : HW'(1) + fcs_len;
        closing   = (ev == EV_CLOSE) || (ev == EV_ABORT);
        close_any = closing && (len_q != '0);
        size_bad  = (len_q <= (LEN_W+1)'(fcs_len)) ||
                    (len_q < {1'b0, cfg_min_len}) ||
                    (len_q > {1'b0, cfg_max_len});
        frame_bad = (ev == EV_ABORT) || size_bad || !fcs_good;
        inc_vec[0] = close_any && (ev == EV_ABORT);
        inc_vec[1] = close_any && (ev != EV_ABORT) && size_bad;
        inc_vec[2] = close_any && (ev != EV_ABORT) && !size_bad && !fcs_good;
    end

    // Hold line, length count and output beat generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_err   <= 1'b0;
            out_drop  <= 1'b0;
            len_q     <= '0;
            held_q    <= '0;
            started_q <= 1'b0;
            for (int i = 0; i < HOLD; i++) line_q[i] <= '0;
        end else begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_err   <= 1'b0;
            out_drop  <= 1'b0;
            if (ev == EV_DATA) begin
                line_q[0] <= ev_byte;
                for (int i = 1; i < HOLD; i++) line_q[i] <= line_q[i-1];
                if (!len_q[LEN_W]) len_q <= len_q + 1'b1;
                if (held_q == depth) begin
                    out_valid <= 1'b1;
                    out_data  <= line_q[depth - HW'(1)];
                    out_sop   <= !started_q;
                    started_q <= 1'b1;
                end else begin
                    held_q <= held_q + 1'b1;
                end
            end else if (closing) begin
                if (close_any) begin
                    out_valid <= 1'b1;
                    out_data  <= line_q[held_q - HW'(1)];
                    out_sop   <= !started_q;
                    out_eop   <= 1'b1;
                    out_err   <= frame_bad && cfg_fwd_err;
                    out_drop  <= frame_bad && !cfg_fwd_err;
                end
                len_q     <= '0;
                held_q    <= '0;
                started_q <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        hdlc_rx_sat_ctr #(.W(CNT_W)) u_ctr (
            .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(inc_vec[g]), .count(cnt_arr[g])
        );
    end

    assign cnt_abort = cnt_arr[0];
    assign cnt_size  = cnt_arr[1];
    assign cnt_fcs   = cnt_arr[2];

    assert_marks_need_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop || out_eop || out_err || out_drop) |-> out_valid);
    assert_err_on_eop_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_err || out_drop) |-> (out_eop && !(out_err && out_drop)));
    assert_empty_close_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (closing && len_q == '0) |=> !out_valid);
    assert_abort_marks_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_ABORT && len_q != '0) |=> (out_eop && (out_err || out_drop)));
    assert_hold_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        held_q <= depth);
endmodule

// File: tb/sim_hdlc_rx_pkt.sv
// Self-checking bench: directed corners plus seeded random frames,
// compared beat by beat against a queue built from the requirements.
module sim_hdlc_rx_pkt;
    localparam int CW   = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        cfg_fcs32 = 1'b0, cfg_keep_fcs = 1'b1, cfg_fwd_err = 1'b1;
    logic [15:0] cfg_min_len = 16'd0, cfg_max_len = 16'd100;
    logic        cnt_clr = 1'b0;
    logic        out_valid, out_sop, out_eop, out_err, out_drop;
    logic [7:0]  out_data;
    logic [CW-1:0] cnt_abort, cnt_size, cnt_fcs;

    always #2.5 clk = ~clk;

    hdlc_rx_pkt #(.LEN_W(16), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .cfg_fcs32(cfg_fcs32), .cfg_keep_fcs(cfg_keep_fcs), .cfg_fwd_err(cfg_fwd_err),
        .cfg_min_len(cfg_min_len), .cfg_max_len(cfg_max_len), .cnt_clr(cnt_clr),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
        .out_err(out_err), .out_drop(out_drop),
        .cnt_abort(cnt_abort), .cnt_size(cnt_size), .cnt_fcs(cnt_fcs)
    );

    typedef struct packed { logic [7:0] d; logic sop, eop, err, drop; } beat_t;
    beat_t exp_q[$];
    int checks = 0, errors = 0;
    int exp_ab = 0, exp_sz = 0, exp_fc = 0;
    string cur_req = "R11";
    bit done = 0;

    // Bench CRC: bit-serial LSB-first, returns the check value to append.
    function automatic logic [31:0] bfcs(input logic [7:0] p[$], input bit w32);
        logic [31:0] c;
        logic fb;
        c = w32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        foreach (p[i]) for (int k = 0; k < 8; k++) begin
            fb = c[0] ^ p[i][k];
            c = c >> 1;
            if (fb) c = c ^ (w32 ? 32'hEDB8_8320 : 32'h0000_8408);
        end
        return w32 ? ~c : {16'h0, ~c[15:0]};
    endfunction

    task automatic check(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Output monitor: every beat is compared with the expected queue (R9).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            beat_t g, e;
            g = '{out_data, out_sop, out_eop, out_err, out_drop};
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s unexpected beat actual=%h expected=none", cur_req, g);
            end else begin
                e = exp_q.pop_front();
                if (g !== e) begin
                    errors++;
                    $display("FAIL %s beat actual=%h expected=%h", cur_req, g, e);
                end
            end
        end
    end

    task automatic put(input logic [7:0] b);
        if ($urandom % 4 == 0) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic put_stuffed(input logic [7:0] b);
        if (b == 8'h7E || b == 8'h7D) begin
            put(8'h7D);
            put(b ^ 8'h20);
        end else put(b);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected beats and counter effect of one closed frame (R5 R6 R7 R8 R9).
    task automatic expect_frame(input logic [7:0] fr[$], input bit aborted, input bit crc_bad);
        int fl, d, len, n;
        bit sz, bad;
        fl  = cfg_fcs32 ? 4 : 2;
        d   = cfg_keep_fcs ? 1 : 1 + fl;
        len = fr.size();
        if (len == 0) return;
        sz  = (len <= fl) || (len < cfg_min_len) || (len > cfg_max_len);
        bad = aborted || sz || crc_bad;
        if (aborted)      begin if (exp_ab < CMAX) exp_ab++; end
        else if (sz)      begin if (exp_sz < CMAX) exp_sz++; end
        else if (crc_bad) begin if (exp_fc < CMAX) exp_fc++; end
        n = (len >= d) ? len - d : 0;
        for (int i = 0; i <= n; i++)
            exp_q.push_back('{fr[i], i == 0, i == n, (i == n) && bad && cfg_fwd_err,
                              (i == n) && bad && !cfg_fwd_err});
    endtask

    // Send payload plus check bytes and a closing flag.
    task automatic frame_p(input logic [7:0] p[$], input bit corrupt);
        logic [7:0] fr[$];
        logic [31:0] f;
        int k;
        fr = p;
        f  = bfcs(p, cfg_fcs32);
        for (int i = 0; i < (cfg_fcs32 ? 4 : 2); i++) fr.push_back(f[8*i +: 8]);
        if (corrupt) begin
            k = $urandom % fr.size();
            fr[k] = fr[k] ^ (8'h01 << ($urandom % 8));
        end
        expect_frame(fr, 1'b0, corrupt);
        foreach (fr[i]) put_stuffed(fr[i]);
        put(8'h7E);
    endtask

    function automatic logic [7:0] rbyte();
        case ($urandom % 8)
            0: return 8'h7E;
            1: return 8'h7D;
            default: return 8'($urandom);
        endcase
    endfunction

    task automatic frame_r(input int plen, input bit corrupt);
        logic [7:0] p[$];
        for (int i = 0; i < plen; i++) p.push_back(rbyte());
        frame_p(p, corrupt);
    endtask

    task automatic abort_frame(input int n);
        logic [7:0] fr[$];
        for (int i = 0; i < n; i++) fr.push_back(rbyte());
        expect_frame(fr, 1'b1, 1'b0);
        foreach (fr[i]) put_stuffed(fr[i]);
        put(8'h7D);
        put(8'h7E);
    endtask

    task automatic set_cfg(input bit w32, input bit keep, input bit fwd,
                           input int mn, input int mx);
        idle(4);
        cfg_fcs32 = w32; cfg_keep_fcs = keep; cfg_fwd_err = fwd;
        cfg_min_len = 16'(mn); cfg_max_len = 16'(mx);
        idle(2);
    endtask

    task automatic drain(input string req);
        idle(10);
        check(req, exp_q.size() == 0, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic check_counters(input string req);
        check({req, " cnt_abort"}, cnt_abort == CW'(exp_ab), cnt_abort, exp_ab);
        check({req, " cnt_size"},  cnt_size  == CW'(exp_sz), cnt_size,  exp_sz);
        check({req, " cnt_fcs"},   cnt_fcs   == CW'(exp_fc), cnt_fcs,   exp_fc);
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] p[$];
        void'($urandom(32'd1234));
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R11: reset state
        check("R11 out_valid", out_valid == 1'b0, out_valid, 0);
        check("R11 counters", {cnt_abort, cnt_size, cnt_fcs} == '0, cnt_abort + cnt_size + cnt_fcs, 0);

        // R1: bytes before the first flag, including an escape, are ignored
        cur_req = "R1";
        put(8'h11); put(8'h7D); put(8'h22); put(8'h33);
        drain("R1");
        put(8'h7E);
        // R2: back-to-back flags give no frame
        cur_req = "R2";
        put(8'h7E); put(8'h7E); put(8'h7E);
        drain("R2");
        check_counters("R2");

        // R3: escaped bytes recovered, incl. 0x7D 0x7D -> 0x5D
        cur_req = "R3";
        set_cfg(0, 1, 1, 0, 100);
        p = '{8'h7E, 8'h7D, 8'h20, 8'h5D, 8'h01};
        frame_p(p, 0);
        put(8'h7D); put(8'h7D); put(8'h7D); put(8'h5E);
        p = '{8'h5D, 8'h7E};
        begin
            logic [7:0] fr[$];
            logic [31:0] f;
            f = bfcs(p, 1'b0);
            fr = '{8'h5D, 8'h7E, f[7:0], f[15:8]};
            expect_frame(fr, 1'b0, 1'b0);
            put_stuffed(f[7:0]); put_stuffed(f[15:8]); put(8'h7E);
        end
        drain("R3");

        // R4: 16-bit and 32-bit check, good and corrupted
        cur_req = "R4";
        frame_r(6, 0); frame_r(6, 1);
        set_cfg(1, 1, 1, 0, 100);
        frame_r(9, 0); frame_r(9, 1); frame_r(1, 0);
        drain("R4");
        check_counters("R4");

        // R5: stripping the check bytes for both widths
        cur_req = "R5";
        set_cfg(1, 0, 1, 0, 100);
        frame_r(5, 0); frame_r(1, 0);
        set_cfg(0, 0, 1, 0, 100);
        frame_r(4, 0); frame_r(1, 1);
        drain("R5");

        // R6: length limits at the edges, and frames no longer than the check
        cur_req = "R6";
        set_cfg(0, 1, 1, 6, 10);
        frame_r(4, 0); frame_r(3, 0); frame_r(8, 0); frame_r(9, 0);
        frame_r(0, 0);
        set_cfg(1, 0, 1, 0, 50);
        frame_r(0, 0);
        put(8'h41); put(8'h42); put(8'h7E);
        begin
            logic [7:0] fr[$];
            fr = '{8'h41, 8'h42};
            expect_frame(fr, 1'b0, 1'b1);
        end
        drain("R6");
        check_counters("R6");

        // R7: abort, and abort winning over size and check failures
        cur_req = "R7";
        abort_frame(5); abort_frame(1);
        put(8'h7D); put(8'h7E);
        drain("R7");
        check_counters("R7");

        // R8: discard marking instead of forwarding marking
        cur_req = "R8";
        set_cfg(0, 1, 0, 3, 20);
        frame_r(5, 1); frame_r(1, 0); frame_r(5, 0); abort_frame(3);
        drain("R8");
        check_counters("R8");

        // R9: random configurations and frames
        cur_req = "R9";
        for (int blk = 0; blk < 15; blk++) begin
            set_cfg($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 9, 6 + $urandom % 25);
            for (int f = 0; f < 20; f++) begin
                if ($urandom % 10 == 0) abort_frame(1 + $urandom % 12);
                else frame_r($urandom % 25, $urandom % 5 == 0);
                if ($urandom % 8 == 0) put(8'h7E);
            end
            drain("R9");
        end
        check_counters("R9");

        // R10: saturation, then clear
        cur_req = "R10";
        for (int i = 0; i < CMAX + 4; i++) abort_frame(2);
        drain("R10");
        check("R10 saturate", cnt_abort == CW'(CMAX), cnt_abort, CMAX);
        @(negedge clk) cnt_clr = 1'b1;
        @(negedge clk) cnt_clr = 1'b0;
        check("R10 clear", {cnt_abort, cnt_size, cnt_fcs} == '0,
              cnt_abort + cnt_size + cnt_fcs, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule